// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block keeps a free-running 32-bit counter next to a 32-bit compare register and raises a timer-pending flag in a status word when an advance of the counter lands on the compare value. The counter moves by one on every cycle in which the tick enable is high, which stands in for a fixed-rate time base. The same status word carries a copy of an external interrupt-controller request line. The block drives one hardware interrupt output to the processor, asserted whenever either of the two status bits is set.

Software writes the counter or the compare register through a one-word write port and reads counter, compare or status through a combinational read port. The pending flag has exactly one acknowledge: a write to the compare register. A coincidence of counter and compare that exists at the moment either register is written never fires. The next match comes only when the counter advances onto the compare value again, which is a full 2^32-step wrap if nothing else is written.

Top module: `cnt_cmp_timer`

## Requirements
- R1: After reset the counter reads 1, the compare register reads 0, the status word reads 0 and `irq_o` is low.
- R2: On each clock edge with `tick_en_i` high and no counter write, the counter increases by one and wraps from 0xFFFFFFFF to 0 with no other effect; with `tick_en_i` low it holds.
- R3: When an increment makes the counter equal the compare value, status bit 15 reads 1 from the cycle in which the counter shows that value, and it stays 1 until the compare register is written.
- R4: A write with `wr_sel_i` = 1 loads the compare register, clears status bit 15 at the same edge, and leaves the counter advancing as if no write had happened.
- R5: A write with `wr_sel_i` = 0 loads the counter with `wr_data_i` (no increment in that cycle) and leaves the compare register and status bit 15 unchanged.
- R6: Counter equal to compare immediately after a write of either register does not set status bit 15; it is set only when a later increment lands on the compare value.
- R7: When a write and a match fall in the same cycle, the write wins: the match is dropped and status bit 15 is not set by it.
- R8: Status bit 10 reads the value `ext_req_i` had at the previous clock edge.
- R9: `irq_o` is the OR of status bits 15 and 10; all other status bits read 0.
- R10: `rd_sel_i` picks the read word: 0 counter, 1 compare, 2 status, 3 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 1 | Counter advance enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 counter, 1 compare |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read select: 0 counter, 1 compare, 2 status, 3 zero |
| rd_data_o | output | 32 | Read data (combinational) |
| ext_req_i | input | 1 | External interrupt-controller request |
| irq_o | output | 1 | Combined hardware interrupt |

## Verification
The counter is run with tick enable held high, held low and toggled, with the compare target placed ahead of it, on it and behind it, so that a match reached by counting is told apart from a coincidence created by a write. Writes are issued in the very cycle an increment would hit the compare value, which separates write priority from match setting for both write targets. A compare value just past the wrap point with the counter near 0xFFFFFFFF shows that the wrap itself has no side effect and that the match still fires afterward. The external request is toggled with the timer flag both clear and set, showing that status bit 10 follows the line one cycle late and that the interrupt output is the OR of the two bits.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int unsigned CNT_W     = 32;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned TIMER_BIT = 15;
    localparam int unsigned EXT_BIT   = 10;

    typedef enum logic [1:0] {
        RD_COUNT   = 2'd0,
        RD_COMPARE = 2'd1,
        RD_STATUS  = 2'd2,
        RD_NONE    = 2'd3
    } rd_sel_e;

    typedef enum logic {
        WR_COUNT   = 1'b0,
        WR_COMPARE = 1'b1
    } wr_sel_e;
endpackage

// File: rtl/tmr_count_unit.sv
`timescale 1ns/1ps
module tmr_count_unit #(
    parameter int unsigned         W         = 32,
    parameter logic [W-1:0]        RST_COUNT = 1,
    parameter logic [W-1:0]        RST_CMP   = 0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_en_i,
    input  logic         cnt_wr_i,
    input  logic         cmp_wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] compare_o,
    output logic         hit_o
);
    typedef struct packed {
        logic [W-1:0] count;
        logic [W-1:0] cmp;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [W-1:0] next_count;

    always_comb begin
        st_d       = st_q;
        next_count = st_q.count + W'(1);
        hit_o      = 1'b0;
        if (cnt_wr_i) begin
            st_d.count = wr_data_i;
        end else if (tick_en_i) begin
            st_d.count = next_count;
        end
        if (cmp_wr_i) begin
            st_d.cmp = wr_data_i;
        end
        // a match only counts when an increment lands on the target
        // and no register write shares the cycle
        if (tick_en_i && !cnt_wr_i && !cmp_wr_i && (next_count == st_q.cmp)) begin
            hit_o = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.count <= RST_COUNT;
            st_q.cmp   <= RST_CMP;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.count;
    assign compare_o = st_q.cmp;
endmodule

// File: rtl/tmr_cause_unit.sv
`timescale 1ns/1ps
module tmr_cause_unit #(
    parameter int unsigned W       = 32,
    parameter int unsigned PEND_IX = 15,
    parameter int unsigned EXT_IX  = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         hit_i,
    input  logic         ack_i,
    input  logic         ext_req_i,
    output logic [W-1:0] cause_o,
    output logic         irq_o
);
    typedef struct packed {
        logic pend;
        logic ext;
    } cause_state_t;

    cause_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ext = ext_req_i;
        if (ack_i) begin
            st_d.pend = 1'b0;
        end else if (hit_i) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b == PEND_IX) begin : g_pend
            assign cause_o[b] = st_q.pend;
        end else if (b == EXT_IX) begin : g_ext
            assign cause_o[b] = st_q.ext;
        end else begin : g_zero
            assign cause_o[b] = 1'b0;
        end
    end

    assign irq_o = st_q.pend | st_q.ext;
endmodule

// File: rtl/tmr_read_mux.sv
`timescale 1ns/1ps
module tmr_read_mux
    import tmr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  rd_sel_e      sel_i,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] compare_i,
    input  logic [W-1:0] cause_i,
    output logic [W-1:0] data_o
);
    always_comb begin
        unique case (sel_i)
            RD_COUNT:   data_o = count_i;
            RD_COMPARE: data_o = compare_i;
            RD_STATUS:  data_o = cause_i;
            default:    data_o = '0;
        endcase
    end
endmodule

// File: rtl/cnt_cmp_timer.sv
`timescale 1ns/1ps
module cnt_cmp_timer
    import tmr_pkg::*;
#(
    parameter int unsigned W         = CNT_W,
    parameter int unsigned PEND_IX   = TIMER_BIT,
    parameter int unsigned EXT_IX    = EXT_BIT
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_en_i,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [1:0]   rd_sel_i,
    output logic [W-1:0] rd_data_o,
    input  logic         ext_req_i,
    output logic         irq_o
);
    localparam logic [W-1:0] RST_COUNT = W'(1);
    localparam logic [W-1:0] RST_CMP   = '0;

    logic         cnt_wr, cmp_wr, hit;
    logic [W-1:0] count_q, compare_q, cause_w;

    assign cnt_wr = wr_en_i && (wr_sel_e'(wr_sel_i) == WR_COUNT);
    assign cmp_wr = wr_en_i && (wr_sel_e'(wr_sel_i) == WR_COMPARE);

    tmr_count_unit #(
        .W         (W),
        .RST_COUNT (RST_COUNT),
        .RST_CMP   (RST_CMP)
    ) u_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_en_i (tick_en_i),
        .cnt_wr_i  (cnt_wr),
        .cmp_wr_i  (cmp_wr),
        .wr_data_i (wr_data_i),
        .count_o   (count_q),
        .compare_o (compare_q),
        .hit_o     (hit)
    );

    tmr_cause_unit #(
        .W       (W),
        .PEND_IX (PEND_IX),
        .EXT_IX  (EXT_IX)
    ) u_cause (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hit_i     (hit),
        .ack_i     (cmp_wr),
        .ext_req_i (ext_req_i),
        .cause_o   (cause_w),
        .irq_o     (irq_o)
    );

    tmr_read_mux #(
        .W (W)
    ) u_rd (
        .sel_i     (rd_sel_e'(rd_sel_i)),
        .count_i   (count_q),
        .compare_i (compare_q),
        .cause_i   (cause_w),
        .data_o    (rd_data_o)
    );
endmodule

// File: rtl/cnt_cmp_timer_chk.sv
`timescale 1ns/1ps
module cnt_cmp_timer_chk #(
    parameter int unsigned W       = 32,
    parameter int unsigned PEND_IX = 15,
    parameter int unsigned EXT_IX  = 10
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         tick_en_i,
    input logic         wr_en_i,
    input logic         wr_sel_i,
    input logic [W-1:0] wr_data_i,
    input logic         ext_req_i,
    input logic         irq_o,
    input logic [W-1:0] count_q,
    input logic [W-1:0] compare_q,
    input logic [W-1:0] cause_w
);
    localparam logic [W-1:0] KNOWN = (W'(1) << PEND_IX) | (W'(1) << EXT_IX);

    assert_cmp_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i) |=> !cause_w[PEND_IX]);

    assert_cnt_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_sel_i) |=> (count_q == $past(wr_data_i)) && (compare_q == $past(compare_q)));

    assert_cnt_runs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && !wr_sel_i) |=> count_q == $past(count_q) + W'($past(tick_en_i)));

    assert_match_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_en_i && !wr_en_i && (count_q + W'(1) == compare_q)) |=> cause_w[PEND_IX]);

    assert_rise_on_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cause_w[PEND_IX]) |-> (count_q == compare_q) && $past(tick_en_i) && !$past(wr_en_i));

    assert_ext_mirror_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> cause_w[EXT_IX] == $past(ext_req_i));

    assert_irq_or_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o == (cause_w[PEND_IX] | cause_w[EXT_IX])) && ($countones(cause_w & ~KNOWN) == 0));
endmodule

bind cnt_cmp_timer cnt_cmp_timer_chk #(
    .W       (W),
    .PEND_IX (PEND_IX),
    .EXT_IX  (EXT_IX)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_en_i (tick_en_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .ext_req_i (ext_req_i),
    .irq_o     (irq_o),
    .count_q   (count_q),
    .compare_q (compare_q),
    .cause_w   (cause_w)
);

// File: tb/test_cnt_cmp_timer.sv
`timescale 1ns/1ps
module test_cnt_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        ext_req = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    cnt_cmp_timer i_cnt_cmp_timer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_en_i (tick_en),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .ext_req_i (ext_req),
        .irq_o     (irq)
    );

    typedef struct {
        int          kind;   // 0..3 read select, 4 interrupt line
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // requirement-level model
    logic [31:0] m_cnt, m_cmp;
    logic        m_pend, m_ext;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            wait (q.size() > 0);
            begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                if (it.kind < 4) rd_sel = 2'(it.kind);
                #0.2;
                act = (it.kind < 4) ? rd_data : {31'd0, irq};
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] cause;
        cause = (32'(m_pend) << 15) | (32'(m_ext) << 10);
        push(0, m_cnt, {tag, " count"});
        push(1, m_cmp, {tag, " compare"});
        push(2, cause, {tag, " status R9"});
        push(3, 32'd0, {tag, " sel3 R10"});
        push(4, {31'd0, m_pend | m_ext}, {tag, " irq R9"});
        wait (q.size() == 0);
        #0.3;
    endtask

    // one clock: drive at negedge, update model at posedge, then check
    task automatic step(input logic tk, input logic we, input logic ws,
                        input logic [31:0] wd, input logic ex, input string tag);
        logic [31:0] inc;
        @(negedge clk);
        tick_en = tk; wr_en = we; wr_sel = ws; wr_data = wd; ext_req = ex;
        @(posedge clk);
        inc = m_cnt + 32'd1;
        if (we && ws) begin
            m_pend = 1'b0;
        end else if (!we && tk && inc == m_cmp) begin
            m_pend = 1'b1;
        end
        if (we && ws) m_cmp = wd;
        if (we && !ws) m_cnt = wd;
        else if (tk) m_cnt = inc;
        m_ext = ex;
        #1;
        check_all(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 32'd0, ext_req, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_cnt = 32'd1; m_cmp = 32'd0; m_pend = 1'b0; m_ext = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1 reset");

        ticks(5, "R2 count up");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 32'd0, 1'b0, "R2 hold");

        // compare write while ticking: count keeps running
        step(1'b1, 1'b1, 1'b1, 32'd12, 1'b0, "R4 compare load runs");
        ticks(8, "R3 reach match");
        ticks(3, "R3 stays pending");
        step(1'b0, 1'b1, 1'b1, 32'd40, 1'b0, "R4 ack clears");

        // coincidence created by writes never fires
        step(1'b0, 1'b1, 1'b0, 32'd100, 1'b0, "R5 count load");
        step(1'b0, 1'b1, 1'b1, 32'd100, 1'b0, "R6 equal at write");
        ticks(3, "R6 no fire past coincidence");
        step(1'b0, 1'b1, 1'b0, 32'd97, 1'b0, "R5 compare kept");
        ticks(4, "R6 fires on reach");
        step(1'b0, 1'b1, 1'b0, 32'd7, 1'b0, "R5 pending kept");

        // write priority
        step(1'b0, 1'b1, 1'b1, 32'd201, 1'b0, "R4 clear");
        step(1'b0, 1'b1, 1'b0, 32'd200, 1'b0, "R5 setup");
        step(1'b1, 1'b1, 1'b1, 32'd500, 1'b0, "R7 compare write wins");
        step(1'b0, 1'b1, 1'b1, 32'd301, 1'b0, "R7 setup");
        step(1'b0, 1'b1, 1'b0, 32'd300, 1'b0, "R7 setup");
        step(1'b1, 1'b1, 1'b0, 32'd50, 1'b0, "R7 count write wins");
        ticks(3, "R7 after");

        // wrap
        step(1'b0, 1'b1, 1'b1, 32'd5, 1'b0, "R2 wrap setup");
        step(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFD, 1'b0, "R2 wrap setup");
        ticks(10, "R2 R6 wrap and match");

        // external request
        step(1'b0, 1'b1, 1'b1, 32'd0, 1'b0, "R4 clear");
        step(1'b0, 1'b0, 1'b0, 32'd0, 1'b1, "R8 ext on");
        step(1'b0, 1'b0, 1'b0, 32'd0, 1'b1, "R8 ext held");
        step(1'b0, 1'b0, 1'b0, 32'd0, 1'b0, "R8 ext off");
        step(1'b0, 1'b1, 1'b1, 32'd9, 1'b1, "R9 setup");
        ticks(4, "R9 both bits");
        step(1'b0, 1'b0, 1'b0, 32'd0, 1'b0, "R9 timer only");

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule